// File: doc/BRIEF.md
# SD/MMC Command Path Controller

This block drives the command line of an SD or MMC card bus. The host presents an 11-bit command control word and a 32-bit argument and pulses a write strobe. The control word holds the 6-bit command index and five flags. The block shifts out a 48-bit command frame, including a CRC7 that it builds while it sends. It can then listen for the card's reply, which is either a 48-bit short response or a 136-bit long response. At the end it reports the received index, up to four response words and a set of status flags.

All line activity advances on `bit_stb_i`, a one-cycle strobe that a bus clock generator raises once per bus clock period. On each strobe the block moves the output line to its next bit and samples the input line. The host may also set two optional holds. One holds the frame back until an external pending input is seen. The other replaces the response timer with a wait for an interrupt request. After every transaction, a recovery gap of bus clocks keeps the block busy before it will accept the next command.

Top module: `sdmmc_cmd_path`

## Requirements
- R1: A write is accepted only when the block is idle and bit 10 (enable) of `cmd_ctrl_i` is set. A write with bit 10 clear leaves `active_o` low and the line undriven.
- R2: The frame goes out MSB first on `cmd_out_o`, one bit per strobe, with `cmd_oe_o` high for exactly 48 strobes. The frame is made of these fields in order: a start bit 0, a direction bit 1, index `cmd_ctrl_i[5:0]`, the argument, the CRC7 (x^7+x^3+1, zero seed) of the first 40 bits, and an end bit 1. When the line is not driven it idles high.
- R3: With bit 9 (pending) set, nothing is driven until `pend_i` is seen high. The frame then follows unchanged.
- R4: With bit 6 (response) clear, `sent_o` rises on the strobe that ends the end bit, and no reply is awaited.
- R5: With bit 6 set and bit 7 clear, a low sample starts a 48-bit reply. `resp_idx_o` then holds reply bits 45:40 and `resp0_o` holds bits 39:8. `resp1_o` to `resp3_o` read zero, and `resp_ok_o` is set when bits 7:1 equal the CRC7 of bits 47:8.
- R6: With bits 6 and 7 set, a 136-bit reply is taken in. `resp0_o`..`resp3_o` hold reply bits 127:0, with the most significant word in `resp0_o`. `resp_idx_o` holds bits 133:128, and the CRC7 is computed over bits 127:8 and compared with bits 7:1.
- R7: A reply whose CRC does not match sets `crc_fail_o` and leaves `resp_ok_o` clear.
- R8: If no start bit is seen within 64 strobes after the end bit, `timeout_o` is set and `active_o` drops at once. A start bit sampled on the 64th strobe is still received.
- R9: With bit 8 (interrupt) set, no timeout occurs. A high `irq_i` during the wait ends it and sets `sent_o`.
- R10: After a send without a reply, a completed reply, or an interrupt, `active_o` stays high for 8 more strobes. Writes made in that time are ignored.
- R11: At most one of `sent_o`, `resp_ok_o`, `crc_fail_o`, `timeout_o` is high. All four, and the response outputs, clear when a command is accepted.
- R12: After reset the block is idle with the line released high, and all flags and response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_i | input | 1 | One-cycle strobe per bus clock period |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_ctrl_i | input | 11 | Index [5:0], response [6], long [7], interrupt [8], pending [9], enable [10] |
| cmd_arg_i | input | 32 | Command argument |
| pend_i | input | 1 | Pending release for the pending mode |
| irq_i | input | 1 | Interrupt request ending an interrupt-mode wait |
| cmd_in_i | input | 1 | Sampled command line from the card |
| cmd_out_o | output | 1 | Command line output value |
| cmd_oe_o | output | 1 | Command line output enable |
| active_o | output | 1 | Command in progress (including the recovery gap) |
| sent_o | output | 1 | Command sent with no reply awaited |
| resp_ok_o | output | 1 | Reply received with good CRC |
| crc_fail_o | output | 1 | Reply CRC mismatch |
| timeout_o | output | 1 | No reply start bit in time |
| resp_idx_o | output | 6 | Received response index |
| resp0_o | output | 32 | Response word, most significant |
| resp1_o | output | 32 | Response word |
| resp2_o | output | 32 | Response word |
| resp3_o | output | 32 | Response word, least significant |

## Verification
The tightest collision is between the response timer running out and the card's start bit arriving on the same strobe. The 64th strobe after the end bit could either end the wait with a timeout or begin a reception. The bench holds the line high for exactly 63 strobes and drops it on the 64th, and it expects a full, CRC-clean reception with no timeout flag. A companion run holds the line high for all 64 strobes and expects the timeout flag with `active_o` already low.

// File: rtl/sdmmc_cmd_pkg.sv
package sdmmc_cmd_pkg;
  localparam int IDX_W      = 6;
  localparam int ARG_W      = 32;
  localparam int WORD_W     = 32;
  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int CTRL_W     = 11;
  // control word flag positions
  localparam int F_RESP = 6;
  localparam int F_LONG = 7;
  localparam int F_INTR = 8;
  localparam int F_PEND = 9;
  localparam int F_EN   = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PEND, ST_SEND, ST_WAIT, ST_RECV, ST_GAP
  } cmd_state_e;
endpackage

// File: rtl/sdmmc_crc7.sv
module sdmmc_crc7 (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [6:0] crc_o
);
  logic [6:0] crc_q;
  logic       fb;

  assign fb    = bit_i ^ crc_q[6];
  assign crc_o = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '0;
    else if (clr_i)  crc_q <= '0;
    else if (en_i)   crc_q <= {crc_q[5:0], 1'b0} ^ {3'b000, fb, 2'b00, fb};
  end
endmodule

// File: rtl/sdmmc_cmd_tx.sv
module sdmmc_cmd_tx #(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [ARG_W-1:0] arg_i,
  input  logic             step_i,
  output logic             bit_o,
  output logic             done_o
);
  localparam int HDR_W   = 2 + IDX_W + ARG_W;
  localparam int FRAME_W = HDR_W + 8;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] HDR_END  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CRC_END  = CNT_W'(HDR_W + 7);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic [HDR_W-1:0] hdr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [6:0]       crc;
  logic [2:0]       crc_sel;
  logic             in_hdr, in_crc;

  assign in_hdr  = cnt_q < HDR_END;
  assign in_crc  = cnt_q < CRC_END;
  assign crc_sel = 3'(CNT_W'(HDR_W + 6) - cnt_q);
  assign bit_o   = in_hdr ? hdr_q[HDR_W-1] : (in_crc ? crc[crc_sel] : 1'b1);
  assign done_o  = step_i && (cnt_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      hdr_q <= {2'b01, idx_i, arg_i};
      cnt_q <= '0;
    end else if (step_i) begin
      if (in_hdr) hdr_q <= {hdr_q[HDR_W-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // running CRC over the header, shifted out right after it
  sdmmc_crc7 i_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load_i),
    .en_i   (step_i && in_hdr),
    .bit_i  (hdr_q[HDR_W-1]),
    .crc_o  (crc)
  );
endmodule

// File: rtl/sdmmc_cmd_rx.sv
module sdmmc_cmd_rx #(
  parameter int SHORT_BITS = 48,
  parameter int LONG_BITS  = 136
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 step_i,
  input  logic                 bit_i,
  input  logic                 long_i,
  output logic                 done_o,
  output logic                 crc_ok_o,
  output logic [LONG_BITS-3:0] bits_o
);
  localparam int CNT_W = $clog2(LONG_BITS + 1);
  localparam int KEEP  = LONG_BITS - 2;
  localparam logic [CNT_W-1:0] S_LAST   = CNT_W'(SHORT_BITS - 1);
  localparam logic [CNT_W-1:0] L_LAST   = CNT_W'(LONG_BITS - 1);
  localparam logic [CNT_W-1:0] S_CRC_HI = CNT_W'(SHORT_BITS - 8);
  localparam logic [CNT_W-1:0] L_CRC_LO = CNT_W'(LONG_BITS - 128);
  localparam logic [CNT_W-1:0] L_CRC_HI = CNT_W'(LONG_BITS - 8);

  logic [KEEP-2:0]  sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [6:0]       crc;
  logic             in_win;

  assign in_win   = long_i ? (cnt_q >= L_CRC_LO && cnt_q < L_CRC_HI) : (cnt_q < S_CRC_HI);
  assign done_o   = step_i && (cnt_q == (long_i ? L_LAST : S_LAST));
  assign crc_ok_o = (crc == sh_q[6:0]);
  assign bits_o   = {sh_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      sh_q  <= {sh_q[KEEP-3:0], bit_i};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  sdmmc_crc7 i_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .en_i   (step_i && in_win),
    .bit_i  (bit_i),
    .crc_o  (crc)
  );
endmodule

// File: rtl/sdmmc_cmd_path.sv
module sdmmc_cmd_path
  import sdmmc_cmd_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 64,
  parameter int GAP_TICKS     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic              cmd_wr_i,
  input  logic [CTRL_W-1:0] cmd_ctrl_i,
  input  logic [ARG_W-1:0]  cmd_arg_i,
  input  logic              pend_i,
  input  logic              irq_i,
  input  logic              cmd_in_i,
  output logic              cmd_out_o,
  output logic              cmd_oe_o,
  output logic              active_o,
  output logic              sent_o,
  output logic              resp_ok_o,
  output logic              crc_fail_o,
  output logic              timeout_o,
  output logic [IDX_W-1:0]  resp_idx_o,
  output logic [WORD_W-1:0] resp0_o,
  output logic [WORD_W-1:0] resp1_o,
  output logic [WORD_W-1:0] resp2_o,
  output logic [WORD_W-1:0] resp3_o
);
  localparam int TMR_W = $clog2(TIMEOUT_TICKS + 1);
  localparam int GAP_W = $clog2(GAP_TICKS + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_TICKS - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_TICKS - 1);

  cmd_state_e          state_q;
  logic                want_q, long_q, intr_q;
  logic [TMR_W-1:0]    tmr_q;
  logic [GAP_W-1:0]    gap_q;
  logic                accept, start_bit, tx_step, tx_bit, tx_done;
  logic                rx_step, rx_done, rx_crc_ok;
  logic [LONG_BITS-3:0] rx_bits;

  assign accept    = (state_q == ST_IDLE) && cmd_wr_i && cmd_ctrl_i[F_EN];
  assign start_bit = bit_stb_i && !cmd_in_i;
  assign tx_step   = (state_q == ST_SEND) && bit_stb_i;
  assign rx_step   = ((state_q == ST_WAIT) && start_bit) || ((state_q == ST_RECV) && bit_stb_i);

  sdmmc_cmd_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W)) i_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .idx_i  (cmd_ctrl_i[IDX_W-1:0]),
    .arg_i  (cmd_arg_i),
    .step_i (tx_step),
    .bit_o  (tx_bit),
    .done_o (tx_done)
  );

  sdmmc_cmd_rx #(.SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS)) i_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tx_done),
    .step_i   (rx_step),
    .bit_i    (cmd_in_i),
    .long_i   (long_q),
    .done_o   (rx_done),
    .crc_ok_o (rx_crc_ok),
    .bits_o   (rx_bits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      want_q     <= 1'b0;
      long_q     <= 1'b0;
      intr_q     <= 1'b0;
      tmr_q      <= '0;
      gap_q      <= '0;
      sent_o     <= 1'b0;
      resp_ok_o  <= 1'b0;
      crc_fail_o <= 1'b0;
      timeout_o  <= 1'b0;
      resp_idx_o <= '0;
      resp0_o    <= '0;
      resp1_o    <= '0;
      resp2_o    <= '0;
      resp3_o    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          want_q     <= cmd_ctrl_i[F_RESP];
          long_q     <= cmd_ctrl_i[F_LONG];
          intr_q     <= cmd_ctrl_i[F_INTR];
          sent_o     <= 1'b0;
          resp_ok_o  <= 1'b0;
          crc_fail_o <= 1'b0;
          timeout_o  <= 1'b0;
          resp_idx_o <= '0;
          resp0_o    <= '0;
          resp1_o    <= '0;
          resp2_o    <= '0;
          resp3_o    <= '0;
          state_q    <= cmd_ctrl_i[F_PEND] ? ST_PEND : ST_SEND;
        end
        ST_PEND: if (pend_i) state_q <= ST_SEND;
        ST_SEND: if (tx_done) begin
          tmr_q <= '0;
          gap_q <= '0;
          if (want_q) state_q <= ST_WAIT;
          else begin
            sent_o  <= 1'b1;
            state_q <= ST_GAP;
          end
        end
        ST_WAIT: begin
          // start bit outranks both the timer and the interrupt
          if (start_bit) state_q <= ST_RECV;
          else if (intr_q) begin
            if (irq_i) begin
              sent_o  <= 1'b1;
              state_q <= ST_GAP;
            end
          end else if (bit_stb_i) begin
            if (tmr_q == TMR_LAST) begin
              timeout_o <= 1'b1;
              state_q   <= ST_IDLE;
            end else tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_RECV: if (rx_done) begin
          resp_ok_o  <= rx_crc_ok;
          crc_fail_o <= !rx_crc_ok;
          if (long_q) begin
            resp_idx_o <= rx_bits[133:128];
            resp0_o    <= rx_bits[127:96];
            resp1_o    <= rx_bits[95:64];
            resp2_o    <= rx_bits[63:32];
            resp3_o    <= rx_bits[31:0];
          end else begin
            resp_idx_o <= rx_bits[45:40];
            resp0_o    <= rx_bits[39:8];
          end
          state_q <= ST_GAP;
        end
        ST_GAP: if (bit_stb_i) begin
          if (gap_q == GAP_LAST) state_q <= ST_IDLE;
          else gap_q <= gap_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_oe_o  = (state_q == ST_SEND);
  assign cmd_out_o = cmd_oe_o ? tx_bit : 1'b1;
  assign active_o  = (state_q != ST_IDLE);
endmodule

// File: rtl/sdmmc_cmd_path_chk.sv
module sdmmc_cmd_path_chk
  import sdmmc_cmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input cmd_state_e state_i,
  input logic       cmd_wr_i,
  input logic       en_i,
  input logic       pend_i,
  input logic       cmd_oe_o,
  input logic       cmd_out_o,
  input logic       active_o,
  input logic       sent_o,
  input logic       resp_ok_o,
  input logic       crc_fail_o,
  input logic       timeout_o
);
  a_r11_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sent_o, resp_ok_o, crc_fail_o, timeout_o}));

  a_r1_start_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(cmd_wr_i && en_i));

  a_r2_drive_only_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_oe_o |-> active_o);

  a_r2_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_oe_o |-> cmd_out_o);

  a_r3_hold_until_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_PEND && !pend_i) |=> !cmd_oe_o);

  a_r8_timeout_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> !active_o);
endmodule

bind sdmmc_cmd_path sdmmc_cmd_path_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state_i    (state_q),
  .cmd_wr_i   (cmd_wr_i),
  .en_i       (cmd_ctrl_i[10]),
  .pend_i     (pend_i),
  .cmd_oe_o   (cmd_oe_o),
  .cmd_out_o  (cmd_out_o),
  .active_o   (active_o),
  .sent_o     (sent_o),
  .resp_ok_o  (resp_ok_o),
  .crc_fail_o (crc_fail_o),
  .timeout_o  (timeout_o)
);

// File: tb/test_sdmmc_cmd_path.sv
module test_sdmmc_cmd_path;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_stb = 1'b0, cmd_wr = 1'b0, pend = 1'b0, irq = 1'b0, cmd_in = 1'b1;
  logic [10:0] cmd_ctrl = '0;
  logic [31:0] cmd_arg = '0;
  logic        cmd_out, cmd_oe, active, sent, resp_ok, crc_fail, timeout;
  logic [5:0]  resp_idx;
  logic [31:0] r0, r1, r2, r3;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  sdmmc_cmd_path i_sdmmc_cmd_path (
    .clk_i(clk), .rst_ni(rst_n), .bit_stb_i(bit_stb), .cmd_wr_i(cmd_wr),
    .cmd_ctrl_i(cmd_ctrl), .cmd_arg_i(cmd_arg), .pend_i(pend), .irq_i(irq),
    .cmd_in_i(cmd_in), .cmd_out_o(cmd_out), .cmd_oe_o(cmd_oe), .active_o(active),
    .sent_o(sent), .resp_ok_o(resp_ok), .crc_fail_o(crc_fail), .timeout_o(timeout),
    .resp_idx_o(resp_idx), .resp0_o(r0), .resp1_o(r1), .resp2_o(r2), .resp3_o(r3)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [135:0] act, input logic [135:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7f(input logic [127:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0} ^ {3'b000, fb, 2'b00, fb};
    end
    return c;
  endfunction

  function automatic logic [47:0] frame48(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h = {2'b01, idx, arg};
    return {h, crc7f({88'b0, h}, 40), 1'b1};
  endfunction

  function automatic logic [47:0] short_resp(input logic [5:0] idx, input logic [31:0] st);
    logic [39:0] h = {2'b00, idx, st};
    return {h, crc7f({88'b0, h}, 40), 1'b1};
  endfunction

  function automatic logic [135:0] long_resp(input logic [119:0] p);
    return {2'b00, 6'h3f, p, crc7f({8'b0, p}, 120), 1'b1};
  endfunction

  function automatic logic [10:0] mk(input logic [5:0] idx, input bit rsp, input bit lng,
                                     input bit intr, input bit pnd);
    return {1'b1, pnd, intr, lng, rsp, idx};
  endfunction

  task automatic tick(input logic cin, output logic o, output logic oe);
    @(negedge clk);
    o = cmd_out; oe = cmd_oe;
    cmd_in = cin; bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0; cmd_in = 1'b1;
  endtask

  task automatic idle_ticks(input int n);
    logic o, oe;
    for (int i = 0; i < n; i++) tick(1'b1, o, oe);
  endtask

  task automatic issue(input logic [10:0] ctrl, input logic [31:0] arg);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_ctrl = ctrl; cmd_arg = arg;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic send_check(input logic [5:0] idx, input logic [31:0] arg, input string req);
    logic [47:0] got, exp;
    logic o, oe;
    bit oe_all = 1'b1;
    exp = frame48(idx, arg);
    for (int i = 47; i >= 0; i--) begin
      tick(1'b1, o, oe);
      got[i] = o;
      oe_all &= oe;
    end
    check(got == exp && oe_all, req, "command frame", {88'b0, got}, {88'b0, exp});
  endtask

  task automatic reply(input logic [135:0] bits, input int n);
    logic o, oe;
    for (int i = n - 1; i >= 0; i--) tick(bits[i], o, oe);
  endtask

  task automatic finish_gap(input string req);
    idle_ticks(7);
    check(active == 1'b1, req, "busy during gap", {135'b0, active}, 136'd1);
    idle_ticks(1);
    check(active == 1'b0, req, "idle after gap", {135'b0, active}, 136'd0);
  endtask

  task automatic run_short(input logic [5:0] idx, input logic [31:0] arg, input logic [5:0] ridx,
                           input logic [31:0] st, input int dly, input bit bad, input string req);
    logic [47:0] rsp = short_resp(ridx, st);
    if (bad) rsp[3] = ~rsp[3];
    issue(mk(idx, 1, 0, 0, 0), arg);
    send_check(idx, arg, req);
    idle_ticks(dly);
    reply({88'b0, rsp}, 48);
    check(resp_ok == !bad && crc_fail == bad && !timeout && !sent, req, "short flags",
          {132'b0, resp_ok, crc_fail, timeout, sent}, {132'b0, !bad, bad, 2'b00});
    check(resp_idx == ridx && r0 == st && r1 == 0 && r2 == 0 && r3 == 0, req, "short fields",
          {resp_idx, r0, r1, r2, r3[31:2]}, {ridx, st, 64'b0, 30'b0});
    finish_gap(req);
  endtask

  task automatic run_long(input logic [5:0] idx, input logic [31:0] arg, input logic [119:0] p,
                          input int dly, input bit bad, input string req);
    logic [135:0] rsp = long_resp(p);
    if (bad) rsp[5] = ~rsp[5];
    issue(mk(idx, 1, 1, 0, 0), arg);
    send_check(idx, arg, req);
    idle_ticks(dly);
    reply(rsp, 136);
    check(resp_ok == !bad && crc_fail == bad, req, "long flags",
          {134'b0, resp_ok, crc_fail}, {134'b0, !bad, bad});
    check({r0, r1, r2, r3} == rsp[127:0] && resp_idx == 6'h3f, req, "long words",
          {2'b0, resp_idx, r0, r1, r2, r3}, {2'b0, 6'h3f, rsp[127:0]});
    finish_gap(req);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic o, oe;
    bit oe_seen;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!active && !cmd_oe && cmd_out && !sent && !resp_ok && !crc_fail && !timeout, "R12",
          "reset outputs", {129'b0, active, cmd_oe, cmd_out, sent, resp_ok, crc_fail, timeout},
          {129'b0, 7'b0010000});
    rst_n = 1'b1;
    @(negedge clk);
    check(resp_idx == 0 && r0 == 0 && r3 == 0, "R12", "reset response", {70'b0, resp_idx, r0, r3},
          136'b0);

    // R1 enable clear: nothing happens
    issue(11'h3c5 & ~11'h400, 32'h1234_5678);
    oe_seen = 1'b0;
    for (int i = 0; i < 5; i++) begin tick(1'b1, o, oe); oe_seen |= oe; end
    check(!active && !oe_seen, "R1", "disabled write", {134'b0, active, oe_seen}, 136'b0);

    // R2/R4 no response, R10 gap ignoring writes
    issue(mk(6'd17, 0, 0, 0, 0), 32'hdead_beef);
    send_check(6'd17, 32'hdead_beef, "R2");
    check(sent && active, "R4", "sent after end bit", {134'b0, sent, active}, {134'b0, 2'b11});
    issue(mk(6'd2, 1, 0, 0, 0), 32'h0);
    oe_seen = 1'b0;
    for (int i = 0; i < 7; i++) begin tick(1'b1, o, oe); oe_seen |= oe; end
    check(active && !oe_seen && sent, "R10", "write in gap ignored",
          {133'b0, active, oe_seen, sent}, {133'b0, 3'b101});
    idle_ticks(1);
    check(!active && sent, "R10", "gap ends after 8", {134'b0, active, sent}, {134'b0, 2'b01});

    // R5 short response, R6 long response, R7 CRC failure
    run_short(6'd13, 32'h0000_aa55, 6'd13, 32'h0000_0900, 3, 0, "R5");
    run_long(6'd2, 32'h0, {30{4'ha}}, 0, 0, "R6");
    run_short(6'd7, 32'h8000_0001, 6'd7, 32'hffff_0000, 1, 1, "R7");
    run_long(6'd9, 32'h4321_0000, {4{30'h2345_6789}}, 2, 1, "R7");

    // R8 timeout on the 64th strobe
    issue(mk(6'd55, 1, 0, 0, 0), 32'h0bad_cafe);
    send_check(6'd55, 32'h0bad_cafe, "R8");
    idle_ticks(63);
    check(!timeout && active, "R8", "no timeout at 63", {134'b0, timeout, active}, {134'b0, 2'b01});
    idle_ticks(1);
    check(timeout && !active, "R8", "timeout at 64", {134'b0, timeout, active}, {134'b0, 2'b10});
    // R11 accept clears flags
    issue(mk(6'd1, 1, 0, 0, 0), 32'h5);
    check(!timeout && active, "R11", "flags cleared on accept", {134'b0, timeout, active},
          {134'b0, 2'b01});
    send_check(6'd1, 32'h5, "R11");
    // R8 boundary: start bit on the 64th strobe still received
    idle_ticks(63);
    reply({88'b0, short_resp(6'd1, 32'h00ff_00ff)}, 48);
    check(resp_ok && !timeout && r0 == 32'h00ff_00ff, "R8", "start bit on last strobe",
          {102'b0, resp_ok, timeout, r0}, {102'b0, 2'b10, 32'h00ff_00ff});
    finish_gap("R10");

    // R9 interrupt mode
    issue(mk(6'd40, 1, 0, 1, 0), 32'h1);
    send_check(6'd40, 32'h1, "R9");
    idle_ticks(100);
    check(!timeout && active && !sent, "R9", "no timer in irq mode",
          {133'b0, timeout, active, sent}, {133'b0, 3'b010});
    @(negedge clk); irq = 1'b1; @(negedge clk); irq = 1'b0;
    check(sent && !timeout && active, "R9", "irq ends wait", {133'b0, sent, timeout, active},
          {133'b0, 3'b101});
    finish_gap("R9");

    // R3 pending hold
    issue(mk(6'd24, 0, 0, 0, 1), 32'h7777_0000);
    oe_seen = 1'b0;
    for (int i = 0; i < 6; i++) begin tick(1'b1, o, oe); oe_seen |= oe; end
    check(active && !oe_seen, "R3", "held before pend", {134'b0, active, oe_seen}, {134'b0, 2'b10});
    @(negedge clk); pend = 1'b1; @(negedge clk); pend = 1'b0;
    send_check(6'd24, 32'h7777_0000, "R3");
    finish_gap("R3");

    // random mix
    for (int k = 0; k < 10; k++) begin
      logic [5:0]  idx = 6'($urandom);
      logic [31:0] arg = $urandom;
      int          kind = int'($urandom % 3);
      int          dly = int'($urandom % 20);
      if (kind == 0) begin
        issue(mk(idx, 0, 0, 0, 0), arg);
        send_check(idx, arg, "R2");
        check(sent, "R4", "random sent", {135'b0, sent}, 136'd1);
        finish_gap("R10");
      end else if (kind == 1) begin
        run_short(idx, arg, 6'($urandom), $urandom, dly, 0, "R5");
      end else begin
        run_long(idx, arg, {$urandom, $urandom, $urandom, 24'($urandom)}, dly, 0, "R6");
      end
    end
    summary();
  end
endmodule